// File: doc/BRIEF.md
# Shared-Cache DMA Read Forwarding Controller

This block is the DMA-read part of a shared second-level cache that sits between several private caches and a global directory. It keeps one coherence state per tracked line. When a forwarded DMA read reaches a line whose data lives in one private cache, the block sends the request on to that cache and parks the line in a blocking state until the private cache acknowledges. It then sends a DMA acknowledgement to the directory. When the shared cache or its writeback buffer holds the data, it replies to the DMA requester at once and acknowledges the directory in the same cycle.

While a line is parked, every request that reaches it is handed back on a recycle channel, unchanged, so that it can be re-queued behind traffic for other lines. A small table of outstanding forwards limits how many lines can be parked at once. Ordinary coherence is not handled here. The neighbouring logic installs line states through a set port and reads them back through a lookup port.

Top module: `dma_fwd_blocker`

## Requirements
- R1: After reset every line reads state code 0 (untracked) and every output valid and payload is low.
- R2: A request of kind 6 (forwarded DMA read) to a line in a local-owner state (codes 1 to 5), with a free table entry, gives on the next cycle a forward with the same line, requestor id and requestor class, and an acknowledgement count of all ones (-1). The line moves to code+15 (blocking codes 16 to 20).
- R3: A local acknowledgement to a line in a blocking state gives a directory acknowledgement for that line on the next cycle. The line returns to code-15, and its table entry is freed for a new forward.
- R4: While a line is blocking, a request of any kind (0 local read, 1 local write, 2 local put, 3 eviction, 4 forwarded read, 5 forwarded write, 6 forwarded DMA read, 7 invalidation, 8 own write) is recycled on the next cycle. Kind, line, id and class are unchanged, the state is unchanged and no other output is raised.
- R5: A forwarded DMA read in codes 6 to 9 (shared-cache owner states) gives a data reply from the array with dirty=1 and from_wb=0, plus a directory acknowledgement in the same cycle. The state is unchanged.
- R6: A forwarded DMA read in codes 10 or 11 (writeback pending) gives a data reply from the writeback buffer with dirty=0, plus a directory acknowledgement, and the line moves to code 11. In code 12 the same reply is sent and the state is kept.
- R7: A forwarded DMA read in codes 13 to 15 (upgrade pending) is recycled and the state is unchanged.
- R8: A local acknowledgement to a line that is not blocking raises ack_err for one cycle. It gives no directory acknowledgement and leaves the state unchanged.
- R9: When all table entries are in use, a forwarded DMA read in a local-owner state is recycled and the state is unchanged.
- R10: At most one of forward, data reply and recycle is raised per cycle. If an acknowledgement that produces a directory acknowledgement coincides with a DMA read that needs a direct reply, the request is recycled.
- R11: The set port writes codes 0 to 15 on the next edge. Codes 16 and above are ignored.
- R12: A request of a kind other than 6 to a non-blocking line gives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_kind | input | 4 | Request kind code |
| req_line | input | LINE_W | Target line |
| req_id | input | ID_W | Requestor identity |
| req_cls | input | CLS_W | Requestor class |
| ack_valid | input | 1 | Local DMA acknowledgement present |
| ack_line | input | LINE_W | Line being acknowledged |
| set_valid | input | 1 | Install a line state |
| set_line | input | LINE_W | Line to install |
| set_state | input | 5 | State code to install |
| rd_line | input | LINE_W | Lookup line |
| rd_state | output | 5 | Current state code of rd_line |
| fwd_valid | output | 1 | Forward to local owner |
| fwd_line | output | LINE_W | Forwarded line |
| fwd_id | output | ID_W | Original requestor id |
| fwd_cls | output | CLS_W | Original requestor class |
| fwd_acks | output | ACK_W | Acknowledgement count, -1 |
| data_valid | output | 1 | Direct data reply |
| data_line | output | LINE_W | Reply line |
| data_id | output | ID_W | Reply destination |
| data_dirty | output | 1 | Dirty flag of reply |
| data_from_wb | output | 1 | Reply sourced from writeback buffer |
| dack_valid | output | 1 | DMA acknowledgement to directory |
| dack_line | output | LINE_W | Acknowledged line |
| recyc_valid | output | 1 | Request handed back for re-queue |
| recyc_kind | output | 4 | Recycled kind |
| recyc_line | output | LINE_W | Recycled line |
| recyc_id | output | ID_W | Recycled requestor id |
| recyc_cls | output | CLS_W | Recycled requestor class |
| ack_err | output | 1 | Acknowledgement in a non-blocking state |

## Verification
A wrong stored state shows up at the next request to that line. A line left blocking recycles traffic it should serve. A line released early answers a second DMA read while the first is outstanding. Each case is also readable one cycle later through the lookup port. A leaked or double-freed table entry shows up as a DMA read recycled with entries apparently free, or forwarded when the table should be full. The bench fills the table to the limit to expose this. Collisions between an acknowledgement and a request in the same cycle are driven explicitly, because that is where two sources compete for the directory acknowledgement.

// File: rtl/dfb_pkg.sv
// Shared codes for the DMA forwarding controller.
// Assumes the blocking codes sit exactly 15 above their local-owner origins.
package dfb_pkg;

    typedef enum logic [3:0] {
        RK_LOC_RD  = 4'd0,
        RK_LOC_WR  = 4'd1,
        RK_LOC_PUT = 4'd2,
        RK_EVICT   = 4'd3,
        RK_FWD_RD  = 4'd4,
        RK_FWD_WR  = 4'd5,
        RK_FWD_DMA = 4'd6,
        RK_INVAL   = 4'd7,
        RK_OWN_WR  = 4'd8
    } req_kind_e;

    typedef enum logic [4:0] {
        LS_NONE      = 5'd0,
        LS_LSH       = 5'd1,
        LS_LSHX      = 5'd2,
        LS_LOWN      = 5'd3,
        LS_LEXC      = 5'd4,
        LS_LOWNX     = 5'd5,
        LS_OWN       = 5'd6,
        LS_OWN_LSH   = 5'd7,
        LS_OWN_LSHX  = 5'd8,
        LS_MOD       = 5'd9,
        LS_WB_MOD    = 5'd10,
        LS_WB_OWN    = 5'd11,
        LS_WB_OLSH   = 5'd12,
        LS_UPG_O     = 5'd13,
        LS_UPG_I     = 5'd14,
        LS_UPG_IO    = 5'd15,
        LS_BLK_LSH   = 5'd16,
        LS_BLK_LSHX  = 5'd17,
        LS_BLK_LOWN  = 5'd18,
        LS_BLK_LEXC  = 5'd19,
        LS_BLK_LOWNX = 5'd20
    } line_state_e;

    localparam logic [4:0] BLK_OFFSET = 5'd15;

    function automatic logic st_blocked(line_state_e s);
        return (s >= LS_BLK_LSH) && (s <= LS_BLK_LOWNX);
    endfunction

    function automatic line_state_e st_to_blocked(line_state_e s);
        return line_state_e'(5'(s) + BLK_OFFSET);
    endfunction

    function automatic line_state_e st_from_blocked(line_state_e s);
        return line_state_e'(5'(s) - BLK_OFFSET);
    endfunction

endpackage

// File: rtl/dfb_state_table.sv
// Per-line state storage with three write ports and a blocked-line count.
// Assumes the caller never targets the same line from the request and ack
// ports in one cycle with conflicting values; the ack port is applied last.
module dfb_state_table
    import dfb_pkg::*;
#(
    parameter int LINES  = 8,
    localparam int LINE_W = $clog2(LINES),
    localparam int CNT_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [LINE_W-1:0] set_line,
    input  logic [4:0]        set_state,
    input  logic              req_we,
    input  logic [LINE_W-1:0] req_line,
    input  line_state_e       req_st_nx,
    input  logic              ack_we,
    input  logic [LINE_W-1:0] ack_line,
    input  line_state_e       ack_st_nx,
    output line_state_e       st_q [LINES],
    output logic [CNT_W-1:0]  blk_cnt
);

    logic set_ok;

    // Install port accepts only stable, non-blocking codes.
    always_comb set_ok = set_en && (set_state <= 5'(LS_UPG_IO));

    // Update the stored line states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LS_NONE;
        end else begin
            if (set_ok) st_q[set_line] <= line_state_e'(set_state);
            if (req_we) st_q[req_line] <= req_st_nx;
            if (ack_we) st_q[ack_line] <= ack_st_nx;
        end
    end

    // Count lines currently parked in a blocking state.
    always_comb begin
        blk_cnt = '0;
        for (int i = 0; i < LINES; i++)
            if (st_blocked(st_q[i])) blk_cnt = blk_cnt + 1'b1;
    end

endmodule

// File: rtl/dfb_txn_table.sv
// Small table of outstanding forwards, one entry per parked line.
// Assumes a free is only requested for a line that holds an entry.
module dfb_txn_table #(
    parameter int ENTRIES = 2,
    parameter int LINE_W  = 3,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              free_en,
    input  logic [LINE_W-1:0] free_line,
    output logic              has_free,
    output logic [CNT_W-1:0]  used_cnt
);

    logic [ENTRIES-1:0] vld;
    logic [LINE_W-1:0]  tag [ENTRIES];
    logic [ENTRIES-1:0] hit;
    logic [IDX_W-1:0]   pick;

    // Find the lowest free entry and the entry matching a freed line.
    always_comb begin
        pick = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!vld[i]) pick = IDX_W'(i);
        for (int i = 0; i < ENTRIES; i++)
            hit[i] = vld[i] && (tag[i] == free_line);
        has_free = ~&vld;
        used_cnt = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (vld[i]) used_cnt = used_cnt + 1'b1;
    end

    // Allocate and release entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < ENTRIES; i++) tag[i] <= '0;
        end else begin
            if (free_en) vld <= vld & ~hit;
            if (alloc_en && has_free) begin
                vld[pick] <= 1'b1;
                tag[pick] <= alloc_line;
            end
        end
    end

    // R3: every release finds its entry.
    assert_free_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> (hit != '0));

endmodule

// File: rtl/dfb_decide.sv
// Combinational action selection for one request and one acknowledgement.
// Assumes states are read before this cycle's updates.
module dfb_decide
    import dfb_pkg::*;
(
    input  logic        req_valid,
    input  logic [3:0]  req_kind,
    input  line_state_e req_st,
    input  logic        tbe_free,
    input  logic        ack_valid,
    input  line_state_e ack_st,
    output logic        do_fwd,
    output logic        do_data,
    output logic        do_wb,
    output logic        do_dirty,
    output logic        do_recyc,
    output logic        do_dack_req,
    output logic        req_we,
    output line_state_e req_st_nx,
    output logic        ack_ok,
    output logic        ack_bad,
    output line_state_e ack_st_nx
);

    // Classify the acknowledgement.
    always_comb begin
        ack_ok    = ack_valid && st_blocked(ack_st);
        ack_bad   = ack_valid && !ack_ok;
        ack_st_nx = st_from_blocked(ack_st);
    end

    // Choose the request action from the line state.
    always_comb begin
        do_fwd      = 1'b0;
        do_data     = 1'b0;
        do_wb       = 1'b0;
        do_dirty    = 1'b0;
        do_recyc    = 1'b0;
        do_dack_req = 1'b0;
        req_we      = 1'b0;
        req_st_nx   = req_st;
        if (req_valid) begin
            if (st_blocked(req_st)) begin
                do_recyc = 1'b1;
            end else if (req_kind == 4'(RK_FWD_DMA)) begin
                case (req_st)
                    LS_LSH, LS_LSHX, LS_LOWN, LS_LEXC, LS_LOWNX: begin
                        if (tbe_free) begin
                            do_fwd    = 1'b1;
                            req_we    = 1'b1;
                            req_st_nx = st_to_blocked(req_st);
                        end else begin
                            do_recyc = 1'b1;
                        end
                    end
                    LS_OWN, LS_OWN_LSH, LS_OWN_LSHX, LS_MOD: begin
                        if (ack_ok) do_recyc = 1'b1;
                        else begin
                            do_data     = 1'b1;
                            do_dirty    = 1'b1;
                            do_dack_req = 1'b1;
                        end
                    end
                    LS_WB_MOD, LS_WB_OWN, LS_WB_OLSH: begin
                        if (ack_ok) do_recyc = 1'b1;
                        else begin
                            do_data     = 1'b1;
                            do_wb       = 1'b1;
                            do_dack_req = 1'b1;
                            if (req_st != LS_WB_OLSH) begin
                                req_we    = 1'b1;
                                req_st_nx = LS_WB_OWN;
                            end
                        end
                    end
                    LS_UPG_O, LS_UPG_I, LS_UPG_IO: do_recyc = 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dma_fwd_blocker.sv
// Shared-cache controller for forwarded DMA reads: forwards to a local owner
// and parks the line, or replies directly, and acknowledges the directory.
// Assumes one request and one local acknowledgement at most per cycle.
module dma_fwd_blocker
    import dfb_pkg::*;
#(
    parameter int LINES   = 8,
    parameter int TBE_N   = 2,
    parameter int ID_W    = 4,
    parameter int CLS_W   = 2,
    parameter int ACK_W   = 4,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [3:0]              req_kind,
    input  logic [LINE_W-1:0]       req_line,
    input  logic [ID_W-1:0]         req_id,
    input  logic [CLS_W-1:0]        req_cls,
    input  logic                    ack_valid,
    input  logic [LINE_W-1:0]       ack_line,
    input  logic                    set_valid,
    input  logic [LINE_W-1:0]       set_line,
    input  logic [4:0]              set_state,
    input  logic [LINE_W-1:0]       rd_line,
    output logic [4:0]              rd_state,
    output logic                    fwd_valid,
    output logic [LINE_W-1:0]       fwd_line,
    output logic [ID_W-1:0]         fwd_id,
    output logic [CLS_W-1:0]        fwd_cls,
    output logic signed [ACK_W-1:0] fwd_acks,
    output logic                    data_valid,
    output logic [LINE_W-1:0]       data_line,
    output logic [ID_W-1:0]         data_id,
    output logic                    data_dirty,
    output logic                    data_from_wb,
    output logic                    dack_valid,
    output logic [LINE_W-1:0]       dack_line,
    output logic                    recyc_valid,
    output logic [3:0]              recyc_kind,
    output logic [LINE_W-1:0]       recyc_line,
    output logic [ID_W-1:0]         recyc_id,
    output logic [CLS_W-1:0]        recyc_cls,
    output logic                    ack_err
);

    localparam int LCNT_W = $clog2(LINES + 1);
    localparam int TCNT_W = $clog2(TBE_N + 1);

    line_state_e       st_q [LINES];
    logic [LCNT_W-1:0] blk_cnt;
    logic [TCNT_W-1:0] tbe_cnt;
    logic              tbe_free;
    logic d_fwd, d_data, d_wb, d_dirty, d_recyc, d_dack, d_we, d_ack_ok, d_ack_bad;
    line_state_e d_req_nx, d_ack_nx;

    dfb_state_table #(.LINES(LINES)) u_states (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_valid), .set_line(set_line), .set_state(set_state),
        .req_we(d_we), .req_line(req_line), .req_st_nx(d_req_nx),
        .ack_we(d_ack_ok), .ack_line(ack_line), .ack_st_nx(d_ack_nx),
        .st_q(st_q), .blk_cnt(blk_cnt)
    );

    dfb_txn_table #(.ENTRIES(TBE_N), .LINE_W(LINE_W)) u_txn (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(d_fwd), .alloc_line(req_line),
        .free_en(d_ack_ok), .free_line(ack_line),
        .has_free(tbe_free), .used_cnt(tbe_cnt)
    );

    dfb_decide u_decide (
        .req_valid(req_valid), .req_kind(req_kind), .req_st(st_q[req_line]),
        .tbe_free(tbe_free), .ack_valid(ack_valid), .ack_st(st_q[ack_line]),
        .do_fwd(d_fwd), .do_data(d_data), .do_wb(d_wb), .do_dirty(d_dirty),
        .do_recyc(d_recyc), .do_dack_req(d_dack), .req_we(d_we),
        .req_st_nx(d_req_nx), .ack_ok(d_ack_ok), .ack_bad(d_ack_bad),
        .ack_st_nx(d_ack_nx)
    );

    // Lookup port for the neighbouring coherence logic.
    always_comb rd_state = 5'(st_q[rd_line]);

    // Register every outgoing channel; payloads are zero when not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0; fwd_line <= '0; fwd_id <= '0; fwd_cls <= '0; fwd_acks <= '0;
            data_valid <= 1'b0; data_line <= '0; data_id <= '0;
            data_dirty <= 1'b0; data_from_wb <= 1'b0;
            dack_valid <= 1'b0; dack_line <= '0;
            recyc_valid <= 1'b0; recyc_kind <= '0; recyc_line <= '0;
            recyc_id <= '0; recyc_cls <= '0;
            ack_err <= 1'b0;
        end else begin
            fwd_valid    <= d_fwd;
            fwd_line     <= d_fwd ? req_line : '0;
            fwd_id       <= d_fwd ? req_id : '0;
            fwd_cls      <= d_fwd ? req_cls : '0;
            fwd_acks     <= d_fwd ? '1 : '0;
            data_valid   <= d_data;
            data_line    <= d_data ? req_line : '0;
            data_id      <= d_data ? req_id : '0;
            data_dirty   <= d_dirty;
            data_from_wb <= d_wb;
            dack_valid   <= d_ack_ok | d_dack;
            dack_line    <= d_ack_ok ? ack_line : (d_dack ? req_line : '0);
            recyc_valid  <= d_recyc;
            recyc_kind   <= d_recyc ? req_kind : '0;
            recyc_line   <= d_recyc ? req_line : '0;
            recyc_id     <= d_recyc ? req_id : '0;
            recyc_cls    <= d_recyc ? req_cls : '0;
            ack_err      <= d_ack_bad;
        end
    end

    // R10: one request outcome per cycle.
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, data_valid, recyc_valid}));

    // R2: a forwarded line is parked when the forward leaves.
    assert_fwd_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> st_blocked(st_q[fwd_line]));

    // R3: parked lines and outstanding table entries stay in step.
    assert_tbe_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(blk_cnt) == int'(tbe_cnt));

    // R4: a recycle always answers a request of the previous cycle.
    assert_recyc_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        recyc_valid |-> $past(req_valid));

    // R8: an error pulse always answers an acknowledgement.
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> $past(ack_valid));

endmodule

// File: tb/dma_fwd_blocker_test.sv
module dma_fwd_blocker_test;
    import dfb_pkg::*;

    localparam int LW = 3, IDW = 4, CW = 2, AW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 0, ack_valid = 0, set_valid = 0;
    logic [3:0] req_kind = 0;
    logic [LW-1:0] req_line = 0, ack_line = 0, set_line = 0, rd_line = 0;
    logic [IDW-1:0] req_id = 0;
    logic [CW-1:0] req_cls = 0;
    logic [4:0] set_state = 0, rd_state;
    logic fwd_valid, data_valid, data_dirty, data_from_wb, dack_valid, recyc_valid, ack_err;
    logic [LW-1:0] fwd_line, data_line, dack_line, recyc_line;
    logic [IDW-1:0] fwd_id, data_id, recyc_id;
    logic [CW-1:0] fwd_cls, recyc_cls;
    logic signed [AW-1:0] fwd_acks;
    logic [3:0] recyc_kind;

    dma_fwd_blocker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_line(req_line), .req_id(req_id), .req_cls(req_cls),
        .ack_valid(ack_valid), .ack_line(ack_line), .set_valid(set_valid),
        .set_line(set_line), .set_state(set_state), .rd_line(rd_line), .rd_state(rd_state),
        .fwd_valid(fwd_valid), .fwd_line(fwd_line), .fwd_id(fwd_id), .fwd_cls(fwd_cls),
        .fwd_acks(fwd_acks), .data_valid(data_valid), .data_line(data_line),
        .data_id(data_id), .data_dirty(data_dirty), .data_from_wb(data_from_wb),
        .dack_valid(dack_valid), .dack_line(dack_line), .recyc_valid(recyc_valid),
        .recyc_kind(recyc_kind), .recyc_line(recyc_line), .recyc_id(recyc_id),
        .recyc_cls(recyc_cls), .ack_err(ack_err)
    );

    typedef struct packed {
        logic fv; logic [LW-1:0] fl; logic [IDW-1:0] fid; logic [CW-1:0] fc; logic [AW-1:0] fa;
        logic dv; logic [LW-1:0] dl; logic [IDW-1:0] did; logic dd; logic dw;
        logic kv; logic [LW-1:0] kl;
        logic rv; logic [3:0] rk; logic [LW-1:0] rl; logic [IDW-1:0] rid; logic [CW-1:0] rc;
        logic er;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int n_run = 0, n_fail = 0;
    logic mon_on = 1'b0;

    function automatic obs_t e_none();
        obs_t o = '0; return o;
    endfunction
    function automatic obs_t e_fwd(int l, int id, int c);
        obs_t o = '0; o.fv = 1; o.fl = LW'(l); o.fid = IDW'(id); o.fc = CW'(c); o.fa = '1; return o;
    endfunction
    function automatic obs_t e_data(int l, int id, bit dirty, bit wb);
        obs_t o = '0; o.dv = 1; o.dl = LW'(l); o.did = IDW'(id); o.dd = dirty; o.dw = wb;
        o.kv = 1; o.kl = LW'(l); return o;
    endfunction
    function automatic obs_t e_dack(int l);
        obs_t o = '0; o.kv = 1; o.kl = LW'(l); return o;
    endfunction
    function automatic obs_t e_rec(int l, int k, int id, int c);
        obs_t o = '0; o.rv = 1; o.rk = 4'(k); o.rl = LW'(l); o.rid = IDW'(id); o.rc = CW'(c); return o;
    endfunction
    function automatic obs_t e_err();
        obs_t o = '0; o.er = 1; return o;
    endfunction

    // Monitor: pop one expected item per cycle or demand idle outputs.
    always @(negedge clk) begin
        if (mon_on) begin
            obs_t got;
            got = '{fwd_valid, fwd_line, fwd_id, fwd_cls, fwd_acks, data_valid, data_line,
                    data_id, data_dirty, data_from_wb, dack_valid, dack_line, recyc_valid,
                    recyc_kind, recyc_line, recyc_id, recyc_cls, ack_err};
            if (exp_q.size() > 0) begin
                obs_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                if (got !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, got, e);
                end
            end else if (got !== '0) begin
                n_run++; n_fail++;
                $display("FAIL R10 stray output actual=%h expected=%h", got, obs_t'('0));
            end
        end
    end

    task automatic drive(bit rv, int k, int l, int id, int c, bit av, int al,
                         bit sv, int sl, int ss, obs_t e, string t);
        @(negedge clk); #1;
        req_valid = rv; req_kind = 4'(k); req_line = LW'(l); req_id = IDW'(id); req_cls = CW'(c);
        ack_valid = av; ack_line = LW'(al);
        set_valid = sv; set_line = LW'(sl); set_state = 5'(ss);
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        req_valid = 0; ack_valid = 0; set_valid = 0;
    endtask

    task automatic do_req(int k, int l, int id, int c, obs_t e, string t);
        drive(1, k, l, id, c, 0, 0, 0, 0, 0, e, t);
    endtask
    task automatic do_ack(int l, obs_t e, string t);
        drive(0, 0, 0, 0, 0, 1, l, 0, 0, 0, e, t);
    endtask
    task automatic do_set(int l, int s);
        drive(0, 0, 0, 0, 0, 0, 0, 1, l, s, e_none(), "R11 set");
    endtask

    task automatic chk_state(int l, int exp, string t);
        rd_line = LW'(l); #1;
        n_run++;
        if (rd_state !== 5'(exp)) begin
            n_fail++;
            $display("FAIL %s line %0d state actual=%0d expected=%0d", t, l, rd_state, exp);
        end
    endtask

    bit done = 0;
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state and idle outputs
        for (int i = 0; i < 8; i++) chk_state(i, 0, "R1 reset");
        n_run++;
        if ({fwd_valid, data_valid, dack_valid, recyc_valid, ack_err} !== 5'b0) begin
            n_fail++;
            $display("FAIL R1 outputs actual=%b expected=00000",
                     {fwd_valid, data_valid, dack_valid, recyc_valid, ack_err});
        end
        mon_on = 1'b1;

        do_set(0, LS_LSH); do_set(1, LS_LSHX); do_set(2, LS_LOWN); do_set(3, LS_LEXC);
        do_set(4, LS_LOWNX); do_set(5, LS_MOD); do_set(6, LS_WB_MOD); do_set(7, LS_UPG_O);
        chk_state(6, 10, "R11 install");

        do_req(RK_FWD_DMA, 0, 3, 1, e_fwd(0, 3, 1), "R2 fwd line0");
        chk_state(0, 16, "R2 park line0");
        do_req(RK_FWD_DMA, 2, 5, 2, e_fwd(2, 5, 2), "R2 fwd line2");
        chk_state(2, 18, "R2 park line2");
        do_req(RK_FWD_DMA, 3, 6, 0, e_rec(3, 6, 6, 0), "R9 table full");
        chk_state(3, 4, "R9 state kept");

        for (int k = 0; k <= 8; k++) do_req(k, 0, 9, 3, e_rec(0, k, 9, 3), "R4 blocked recycle");
        chk_state(0, 16, "R4 still parked");

        do_ack(5, e_err(), "R8 stray ack");
        chk_state(5, 9, "R8 state kept");
        do_ack(0, e_dack(0), "R3 ack line0");
        chk_state(0, 1, "R3 back to origin");
        do_req(RK_FWD_DMA, 3, 6, 0, e_fwd(3, 6, 0), "R3 entry freed");
        chk_state(3, 19, "R2 park line3");

        do_req(RK_FWD_DMA, 5, 7, 1, e_data(5, 7, 1, 0), "R5 data mod");
        chk_state(5, 9, "R5 state kept");
        for (int s = 6; s <= 8; s++) begin
            do_set(5, s);
            do_req(RK_FWD_DMA, 5, 4, 0, e_data(5, 4, 1, 0), "R5 data owner");
            chk_state(5, s, "R5 state kept");
        end
        do_set(5, LS_MOD);

        do_req(RK_FWD_DMA, 6, 2, 1, e_data(6, 2, 0, 1), "R6 wb reply");
        chk_state(6, 11, "R6 to wb-owned");
        do_req(RK_FWD_DMA, 6, 2, 1, e_data(6, 2, 0, 1), "R6 wb reply again");
        chk_state(6, 11, "R6 stays");

        do_req(RK_FWD_DMA, 7, 1, 0, e_rec(7, 6, 1, 0), "R7 upgrade recycle");
        chk_state(7, 13, "R7 state kept");
        do_set(7, LS_WB_OLSH);
        chk_state(7, 12, "R11 install");
        do_req(RK_FWD_DMA, 7, 8, 2, e_data(7, 8, 0, 1), "R6 wb shared reply");
        chk_state(7, 12, "R6 state kept");

        do_set(5, 16);
        chk_state(5, 9, "R11 blocking code ignored");

        drive(1, RK_FWD_DMA, 5, 1, 0, 1, 2, 0, 0, 0, e_dack(2) | e_rec(5, 6, 1, 0),
              "R10 ack wins");
        chk_state(2, 3, "R10 ack applied");
        chk_state(5, 9, "R10 request untouched");

        do_req(RK_FWD_RD, 5, 2, 0, e_none(), "R12 non-dma ignored");
        chk_state(5, 9, "R12 state kept");

        do_ack(3, e_dack(3), "R3 ack line3");
        chk_state(3, 4, "R3 back to origin");

        do_req(RK_FWD_DMA, 1, 11, 3, e_fwd(1, 11, 3), "R2 fwd line1");
        chk_state(1, 17, "R2 park line1");
        drive(1, RK_FWD_DMA, 1, 12, 1, 1, 1, 0, 0, 0, e_dack(1) | e_rec(1, 6, 12, 1),
              "R4 same-line ack and request");
        chk_state(1, 2, "R3 back to origin");
        do_req(RK_FWD_DMA, 4, 13, 2, e_fwd(4, 13, 2), "R2 fwd line4");
        chk_state(4, 20, "R2 park line4");
        do_ack(4, e_dack(4), "R3 ack line4");
        chk_state(4, 5, "R3 back to origin");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule